// File: doc/BRIEF.md
# Parallel flash identification probe

This block runs a one-shot identification sequence against an 8-bit parallel NOR flash through a simple memory-bus master port. A start pulse sends the identify command and waits a fixed settling time. The block then reads the manufacturer byte and a device byte and puts the flash back into array-read mode. After that it reports the 16-bit identifier and the device capacity it implies. An identifier that matches neither known value raises an error flag.

The position of the device byte depends on the manufacturer byte. A manufacturer byte of 0xB0 places the device byte at offset 2. Any other manufacturer byte places it at offset 1. Start-up logic holds off any other flash traffic until `done` rises, then uses `size_sel` to pick the array size or halts on `id_error`.

Top module: `flash_id_probe`

## Requirements
- R1: While reset is held and after it is released, `done`, `id`, `size_sel` and `id_error` are 0, and neither bus strobe is active.
- R2: A start pulse sampled while idle produces, in the next cycle, one write cycle (`bus_wr`=1) of byte 0x90 to offset 0x8000.
- R3: The first read (`bus_rd`=1) is at offset 0. It is issued exactly WAIT_CYC+1 clock edges after the identify write, with no strobe in between. WAIT_CYC = CLK_HZ/1e6 × WAIT_US, which is 1500 at the defaults.
- R4: The second read is at offset 2 when the first byte read is 0xB0, and at offset 1 otherwise. It comes exactly two cycles after the first read.
- R5: Read data is taken from `bus_rdata` in the cycle right after the strobe cycle. Data presented at any other time is not used.
- R6: `id` equals the first byte in bits 15:8 and the second byte in bits 7:0.
- R7: After the second read, one write of 0xFF to offset 0x8000 restores array-read mode. A probe makes exactly two writes and two reads.
- R8: Identifier 0x89A6 gives `size_sel`=0 (1 MiB) and `id_error`=0. Identifier 0xB0D4 gives `size_sel`=1 (4 MiB) and `id_error`=0.
- R9: Any other identifier gives `id_error`=1 and `size_sel`=0.
- R10: `done` rises at the clock edge WAIT_CYC+6 cycles after the start edge. The results then stay unchanged until the next accepted start, which clears `done` at its own edge.
- R11: A start pulse that arrives during a probe is ignored. The sequence timing and bus traffic are unchanged.
- R12: `bus_wr` and `bus_rd` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run a probe |
| bus_addr | output | ADDR_W | Byte offset within the flash window |
| bus_wdata | output | 8 | Command byte for write cycles |
| bus_rdata | input | 8 | Read data, valid the cycle after a read strobe |
| bus_wr | output | 1 | Write strobe, one cycle per write |
| bus_rd | output | 1 | Read strobe, one cycle per read |
| done | output | 1 | Probe finished; results are valid |
| id | output | 16 | Identifier read from the device |
| size_sel | output | 1 | 0 = 1 MiB device, 1 = 4 MiB device |
| id_error | output | 1 | Identifier not recognised |

## Verification
The embedded assertions check four properties on every cycle. The two strobes are exclusive. The wait counter never passes its limit. The error and large-size flags never appear together. Once `done` is up, the results hold and `done` only rises right after the restore write.

The scenarios cover what no single-cycle property can see. They check the exact spacing of the identify write and the first read, and the offset chosen for the second byte under each manufacturer byte. They also check that data is taken on the correct cycle, since the flash model drives junk outside that cycle. The remaining scenarios cover decoding of both known parts and two unknown ones, and a start pulse landing in the middle of a probe.

// File: rtl/flash_id_pkg.sv
// Shared constants and the sequencer state type for the flash identification probe.
// Assumes a byte-wide flash whose command codes and identifiers are fixed.
package flash_id_pkg;

    localparam logic [7:0] CMD_IDENTIFY   = 8'h90;
    localparam logic [7:0] CMD_ARRAY_READ = 8'hFF;
    localparam logic [7:0] MFR_WIDE_ID    = 8'hB0;   // manufacturer byte that moves the device byte to offset 2

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_RD_HI,
        ST_CAP_HI,
        ST_RD_LO,
        ST_CAP_LO,
        ST_RESTORE
    } probe_state_t;

endpackage

// File: rtl/probe_wait_timer.sv
// Settling-time counter: counts LIMIT cycles while run is high and pulses expired on the last one.
// Assumes LIMIT >= 1; the count restarts from zero whenever run drops.
module probe_wait_timer #(
    parameter int LIMIT = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == CNT_W'(LIMIT - 1));

    // Advance the count while running; hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TIMER_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < LIMIT);   // R3

endmodule

// File: rtl/probe_sequencer.sv
// Bus sequencer for the probe: identify write, settle, two byte reads, restore write.
// Assumes single-cycle write strobes and read data valid one cycle after the read strobe.
module probe_sequencer
    import flash_id_pkg::*;
#(
    parameter int          ADDR_W  = 22,
    parameter logic [31:0] CMD_OFS = 32'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wait_done,
    input  logic [7:0]        rdata,
    output logic              idle,
    output logic              wait_run,
    output logic              finish,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [7:0]        hi_byte,
    output logic [7:0]        lo_byte
);
    probe_state_t state, state_nx;
    logic [ADDR_W-1:0] lo_addr;

    assign idle     = (state == ST_IDLE);
    assign wait_run = (state == ST_WAIT);
    assign finish   = (state == ST_RESTORE);
    assign lo_addr  = (hi_byte == MFR_WIDE_ID) ? ADDR_W'(2) : ADDR_W'(1);

    // Next-state selection for the fixed probe sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_CMD;
            ST_CMD:     state_nx = ST_WAIT;
            ST_WAIT:    if (wait_done) state_nx = ST_RD_HI;
            ST_RD_HI:   state_nx = ST_CAP_HI;
            ST_CAP_HI:  state_nx = ST_RD_LO;
            ST_RD_LO:   state_nx = ST_CAP_LO;
            ST_CAP_LO:  state_nx = ST_RESTORE;
            ST_RESTORE: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Bus strobes, address and command byte decoded from the current state.
    always_comb begin
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = '0;
        bus_wdata = 8'h00;
        unique case (state)
            ST_CMD: begin
                bus_wr    = 1'b1;
                bus_addr  = ADDR_W'(CMD_OFS);
                bus_wdata = CMD_IDENTIFY;
            end
            ST_RD_HI: bus_rd = 1'b1;
            ST_RD_LO: begin
                bus_rd   = 1'b1;
                bus_addr = lo_addr;
            end
            ST_RESTORE: begin
                bus_wr    = 1'b1;
                bus_addr  = ADDR_W'(CMD_OFS);
                bus_wdata = CMD_ARRAY_READ;
            end
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture each ID byte in the cycle after its read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_byte <= 8'h00;
            lo_byte <= 8'h00;
        end else begin
            if (state == ST_CAP_HI) hi_byte <= rdata;
            if (state == ST_CAP_LO) lo_byte <= rdata;
        end
    end

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));   // R12

endmodule

// File: rtl/probe_id_decode.sv
// Identifier decoder: matches the 16-bit identifier against the two known parts.
// Assumes exactly two supported capacities; anything else is reported as unknown.
module probe_id_decode #(
    parameter logic [15:0] ID_SMALL = 16'h89A6,
    parameter logic [15:0] ID_LARGE = 16'hB0D4
) (
    input  logic [15:0] ident,
    output logic        is_large,
    output logic        unknown
);
    // Compare against each supported identifier.
    always_comb begin
        is_large = (ident == ID_LARGE);
        unknown  = !(is_large || (ident == ID_SMALL));
    end

endmodule

// File: rtl/flash_id_probe.sv
// Top of the flash identification probe: sequencer, settling timer, decoder and result registers.
// Assumes start pulses last one cycle; results hold until the next accepted start.
module flash_id_probe
    import flash_id_pkg::*;
#(
    parameter int          CLK_HZ   = 100_000_000,
    parameter int          WAIT_US  = 15,
    parameter int          ADDR_W   = 22,
    parameter logic [31:0] CMD_OFS  = 32'h8000,
    parameter logic [15:0] ID_SMALL = 16'h89A6,
    parameter logic [15:0] ID_LARGE = 16'hB0D4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic              done,
    output logic [15:0]       id,
    output logic              size_sel,
    output logic              id_error
);
    localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * WAIT_US;

    logic       idle, wait_run, wait_done, finish;
    logic [7:0] hi_byte, lo_byte;
    logic       is_large, unknown;

    probe_sequencer #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .wait_done(wait_done),
        .rdata(bus_rdata), .idle(idle), .wait_run(wait_run), .finish(finish),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .hi_byte(hi_byte), .lo_byte(lo_byte)
    );

    probe_wait_timer #(.LIMIT(WAIT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(wait_run), .expired(wait_done)
    );

    probe_id_decode #(.ID_SMALL(ID_SMALL), .ID_LARGE(ID_LARGE)) u_dec (
        .ident({hi_byte, lo_byte}), .is_large(is_large), .unknown(unknown)
    );

    // Result registers: cleared by an accepted start, loaded on the restore write.
    always_ff @(posedge clk) begin
        if (!rst_n || (start && idle)) begin
            done     <= 1'b0;
            id       <= 16'h0000;
            size_sel <= 1'b0;
            id_error <= 1'b0;
        end else if (finish) begin
            done     <= 1'b1;
            id       <= {hi_byte, lo_byte};
            size_sel <= is_large;
            id_error <= unknown;
        end
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(id) && $stable(size_sel) && $stable(id_error)));   // R10

    AST_ERR_NOT_SIZED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(id_error && size_sel));   // R9

    AST_DONE_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(bus_wr) && $past(bus_wdata) == CMD_ARRAY_READ));   // R7

endmodule

// File: tb/flash_id_probe_bench.sv
// Directed bench for the flash identification probe with a behavioural flash model.
module flash_id_probe_bench;
    localparam int ADDR_W   = 22;
    localparam int WAIT_CYC = 1500;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic [7:0]        bus_rdata;
    logic              bus_wr, bus_rd;
    logic              done, size_sel, id_error;
    logic [15:0]       id;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    flash_id_probe u_flash_id_probe (
        .clk(clk), .rst_n(rst_n), .start(start),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd),
        .done(done), .id(id), .size_sel(size_sel), .id_error(id_error)
    );

    // Flash model: identify mode and logging of every bus cycle.
    logic [7:0] id_b0, id_b1, id_b2;
    bit         id_mode = 0;
    bit         rd_in_array = 0;
    bit         both_strobes = 0;
    int         cyc = 0;
    int         wr_n = 0, rd_n = 0;
    int         wr_cyc [4];
    int         rd_cyc [4];
    logic [31:0] wr_adr [4];
    logic [7:0]  wr_dat [4];
    logic [31:0] rd_adr [4];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        bus_rdata <= 8'hEE;
        if (bus_wr && bus_rd) both_strobes <= 1;
        if (bus_wr) begin
            if (wr_n < 4) begin
                wr_cyc[wr_n] <= cyc + 1;
                wr_adr[wr_n] <= 32'(bus_addr);
                wr_dat[wr_n] <= bus_wdata;
            end
            wr_n <= wr_n + 1;
            if (bus_wdata == 8'h90) id_mode <= 1;
            if (bus_wdata == 8'hFF) id_mode <= 0;
        end
        if (bus_rd) begin
            if (rd_n < 4) begin
                rd_cyc[rd_n] <= cyc + 1;
                rd_adr[rd_n] <= 32'(bus_addr);
            end
            rd_n <= rd_n + 1;
            if (!id_mode) rd_in_array <= 1;
            if (!id_mode)            bus_rdata <= 8'h5A;
            else if (bus_addr == 0)  bus_rdata <= id_b0;
            else if (bus_addr == 1)  bus_rdata <= id_b1;
            else if (bus_addr == 2)  bus_rdata <= id_b2;
            else                     bus_rdata <= 8'h00;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Reset scenario: outputs and strobes quiet during and after reset.
    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!done && id == 0 && !size_sel && !id_error, "R1 outputs in reset", {done, id, size_sel, id_error}, 0);
        check(!bus_wr && !bus_rd, "R1 strobes in reset", {bus_wr, bus_rd}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!done && id == 0 && !size_sel && !id_error, "R1 outputs after reset", {done, id, size_sel, id_error}, 0);
        check(!bus_wr && !bus_rd && wr_n == 0 && rd_n == 0, "R1 no bus traffic", wr_n + rd_n, 0);
    endtask

    // One probe scenario with programmed ID bytes; inject adds a start pulse mid-probe.
    task automatic run_probe(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                             input logic [15:0] exp_id, input bit exp_large, input bit exp_err,
                             input bit inject);
        int s;
        int done_cyc;
        logic [31:0] exp_lo;
        id_b0 = b0; id_b1 = b1; id_b2 = b2;
        wr_n = 0; rd_n = 0; rd_in_array = 0;
        s = cyc + 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done, "R10 start clears done", done, 0);
        if (inject) begin
            repeat (100) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        done_cyc = -1;
        for (int k = 0; k < WAIT_CYC + 40; k++) begin
            if (done) begin
                done_cyc = cyc;
                break;
            end
            @(negedge clk);
        end
        check(done_cyc == s + WAIT_CYC + 6, "R10 done timing", done_cyc - s, WAIT_CYC + 6);
        check(wr_n == 2 && rd_n == 2, inject ? "R11 traffic count" : "R7 traffic count", wr_n * 16 + rd_n, 32'h22);
        check(wr_cyc[0] == s + 1 && wr_adr[0] == 32'h8000 && wr_dat[0] == 8'h90, "R2 identify write",
              wr_adr[0] + 32'(wr_dat[0]), 32'h8090);
        check(rd_cyc[0] - wr_cyc[0] == WAIT_CYC + 1 && rd_adr[0] == 0, "R3 first read spacing",
              rd_cyc[0] - wr_cyc[0], WAIT_CYC + 1);
        exp_lo = (b0 == 8'hB0) ? 32'd2 : 32'd1;
        check(rd_adr[1] == exp_lo && rd_cyc[1] == rd_cyc[0] + 2, "R4 second read offset", rd_adr[1], exp_lo);
        check(wr_adr[1] == 32'h8000 && wr_dat[1] == 8'hFF && !id_mode, "R7 restore write",
              32'(wr_dat[1]), 32'hFF);
        check(!rd_in_array, "R5 reads in identify mode", rd_in_array, 0);
        check(id == exp_id, "R6 identifier", id, exp_id);
        check(size_sel == exp_large && id_error == exp_err, exp_err ? "R9 unknown flag" : "R8 size decode",
              {size_sel, id_error}, {exp_large, exp_err});
        repeat (20) @(negedge clk);
        check(done && id == exp_id && size_sel == exp_large && id_error == exp_err, "R10 results held",
              id, exp_id);
        check(!both_strobes, "R12 strobes exclusive", both_strobes, 0);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        run_probe(8'h89, 8'hA6, 8'h33, 16'h89A6, 1'b0, 1'b0, 1'b0);
        run_probe(8'hB0, 8'h11, 8'hD4, 16'hB0D4, 1'b1, 1'b0, 1'b0);
        run_probe(8'h12, 8'h34, 8'hD4, 16'h1234, 1'b0, 1'b1, 1'b0);
        run_probe(8'hB0, 8'hD4, 8'h00, 16'hB000, 1'b0, 1'b1, 1'b0);
        run_probe(8'h89, 8'hA6, 8'hD4, 16'h89A6, 1'b0, 1'b0, 1'b1);
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule